// File: doc/BRIEF.md
# Floppy Controller Host Register Interface

This block is the byte-wide register file that a host processor sees on a floppy disk controller. It decodes a register address on every read or write strobe. It holds the setup values the drive engines consume: the phase lines, the step count, the first sector, the transfer count and the gap size. It also keeps the mode word that launches and halts two engines, one that moves the head and one that reads from the disk. Both engines sit outside the block. They see only one-cycle start and stop pulses, and they report back through step-done, header-found and error strobes.

The mode word is never written as a whole. One address ORs the written bits in, and a second address clears them. A set or clear that carries the stepping bit controls the stepping engine; otherwise the access bit controls the access engine. A start is refused, and the refusal is recorded, when either engine is already running, when the stepping command address on the phase lines is wrong, or when write mode is requested. Interrupt flags and errors accumulate in clear-on-read registers. A level interrupt is raised while any unmasked flag is set.

Reads are combinational: `rdata` reflects `addr` in the same cycle, and the clear caused by reading takes effect at the clock edge that ends the read. There is no data stream through this block, so every pin is a plain control or status signal with no valid/ready handshake.

Top module: `fdc_regif`

## Requirements
- R1: After reset the mode, interrupt-flag, error, mask, phase, step-count, track, sector, format, transfer-count and gap registers are 0, the first-sector register is 0xFF, `irq_o` is low and no engine pulse is active.
- R2: Address map (4-bit): 0 error (read-clear), 1 phase, 2 step count, 3 mode clear-bits write / mode read, 4 mode set-bits write / mode read, 5 interrupt flags (read-clear), 6 interrupt mask, 7 current track, 8 current sector, 9 gap write / format read, 10 first sector, 11 transfer count; addresses 12..15 read 0.
- R3: Mode bits: 3 = access go, 4 = write mode (`wr_mode_o`), 5 = high bit of the step command address, 7 = step go. A set-bits write ORs every bit except 3 and 7 into the mode word. A clear-bits write clears every bit it carries.
- R4: A set-bits write that carries bit 7 is a step request and ignores bit 3. It is accepted only if neither go bit is set and {mode bit 5 after the OR, phase bits 1:0} equals STEP_CMD (default 3'b000). Acceptance sets bit 7 and raises `step_start_o` for exactly the cycle after the write.
- R5: A set-bits write that carries bit 3 but not bit 7 is an access request. It is accepted only if neither go bit is set and write mode is clear after the OR. Acceptance sets bit 3 and pulses `acc_start_o` for one cycle.
- R6: A refused request changes neither go bit, gives no pulse, and sets exactly one error bit, chosen in priority order: bit 0 if an engine is busy, bit 1 if the step command address does not match, bit 2 if write mode is set.
- R7: A clear-bits write carrying bit 7 while stepping pulses `step_stop_o`. One carrying bit 3 without bit 7 while accessing pulses `acc_stop_o`.
- R8: `step_done_i` while stepping clears mode bit 7 and sets flag bit 1. While not stepping it has no effect.
- R9: `hdr_valid_i` while accessing loads the track, sector and format registers and sets flag bit 2. While not accessing it changes neither those registers nor the flags.
- R10: Reading address 5 returns the flags and clears them, but a flag event in the same cycle survives the clear.
- R11: Reading address 0 returns the errors and clears them. Errors from refusals and from `eng_err_i` are ORed in, and a new error in the same cycle as the read survives.
- R12: `irq_o` is high exactly when the flags ANDed with the mask are nonzero.
- R13: Phase, step count, mask, first sector and transfer count read back as written and drive their outputs. A gap write drives `gap_o` only.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe (triggers read-clear) |
| addr | input | AW | Register address |
| wdata | input | DW | Write data |
| rdata | output | DW | Read data for `addr`, combinational |
| phase_o | output | DW | Phase line register |
| step_cnt_o | output | DW | Step count for the stepping engine |
| first_sec_o | output | DW | First sector to match |
| xfer_cnt_o | output | DW | Sectors to transfer |
| gap_o | output | DW | Gap size |
| wr_mode_o | output | 1 | Mode write-select bit |
| step_start_o | output | 1 | One-cycle stepping start |
| step_stop_o | output | 1 | One-cycle stepping stop |
| acc_start_o | output | 1 | One-cycle access start |
| acc_stop_o | output | 1 | One-cycle access stop |
| step_done_i | input | 1 | Stepping engine finished |
| hdr_valid_i | input | 1 | Address header read by the access engine |
| hdr_track_i | input | DW | Track byte of that header |
| hdr_sector_i | input | DW | Sector byte of that header |
| hdr_format_i | input | DW | Format byte of that header |
| eng_err_i | input | DW | Error bits from the engines, ORed in |
| irq_o | output | 1 | Level interrupt |

## Verification
The two functions that can meet in one cycle are the host's clearing read and an engine event: a flag or error read in the same cycle as `hdr_valid_i` or `eng_err_i`. The bench provokes this by holding the event strobe and the read strobe in the same clock cycle. It checks that the read returns the value from before the event, and that a second read returns the new bit. A similar collision is a start request that arrives while the other engine runs. The bench judges it by the missing pulse, the unchanged go bits and the busy error bit.

// File: rtl/fdc_pkg.sv
package fdc_pkg;
  // register addresses
  localparam int A_ERR      = 0;
  localparam int A_PHASE    = 1;
  localparam int A_STEP     = 2;
  localparam int A_MODE_CLR = 3;
  localparam int A_MODE_SET = 4;
  localparam int A_IFLAG    = 5;
  localparam int A_IMASK    = 6;
  localparam int A_TRACK    = 7;
  localparam int A_SECTOR   = 8;
  localparam int A_GAPFMT   = 9;
  localparam int A_FIRST    = 10;
  localparam int A_XFER     = 11;

  // mode word bit positions
  localparam int M_GO     = 3;
  localparam int M_WR     = 4;
  localparam int M_CMDHI  = 5;
  localparam int M_GOSTEP = 7;

  // interrupt flag bit positions
  localparam int F_STEP = 1;
  localparam int F_HDR  = 2;

  // error bit positions
  localparam int E_BUSY  = 0;
  localparam int E_CMD   = 1;
  localparam int E_WRITE = 2;
endpackage

// File: rtl/fdc_evt_reg.sv
module fdc_evt_reg #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rd_clr,
  input  logic [DW-1:0] set_bits,
  output logic [DW-1:0] q
);
  logic [DW-1:0] held;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= held | set_bits;
  end

  always_comb held = rd_clr ? '0 : q;

  // R10
  new_bit_survives_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (set_bits != '0) |=> ((q & $past(set_bits)) == $past(set_bits)));

  // R11
  read_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_clr && set_bits == '0) |=> (q == '0));
endmodule

// File: rtl/fdc_mode_ctl.sv
module fdc_mode_ctl
  import fdc_pkg::*;
#(
  parameter int         DW       = 8,
  parameter logic [2:0] STEP_CMD = 3'b000
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          set_we,
  input  logic          clr_we,
  input  logic [DW-1:0] wdata,
  input  logic [1:0]    phase,
  input  logic          step_done,
  output logic [DW-1:0] mode,
  output logic          step_evt,
  output logic [DW-1:0] err_set,
  output logic          step_start,
  output logic          step_stop,
  output logic          acc_start,
  output logic          acc_stop
);
  localparam logic [DW-1:0] ENG_MASK = (DW'(1) << M_GO) | (DW'(1) << M_GOSTEP);

  logic [DW-1:0] mode_d, merged;
  logic [2:0]    cmd;
  logic busy, want_step, want_acc, cmd_ok, step_ok, acc_ok;
  logic step_stop_d, acc_stop_d;

  always_comb begin
    busy      = mode[M_GO] | mode[M_GOSTEP];
    merged    = mode | wdata;
    cmd       = {merged[M_CMDHI], phase};
    cmd_ok    = (cmd == STEP_CMD);
    want_step = set_we & wdata[M_GOSTEP];
    want_acc  = set_we & ~wdata[M_GOSTEP] & wdata[M_GO];
    step_ok   = want_step & ~busy & cmd_ok;
    acc_ok    = want_acc & ~busy & ~merged[M_WR];
    step_evt  = step_done & mode[M_GOSTEP];

    err_set = '0;
    if ((want_step | want_acc) & busy) err_set[E_BUSY]  = 1'b1;
    else if (want_step & ~cmd_ok)      err_set[E_CMD]   = 1'b1;
    else if (want_acc & merged[M_WR])  err_set[E_WRITE] = 1'b1;

    mode_d = mode;
    if (set_we) begin
      mode_d           = mode | (wdata & ~ENG_MASK);
      mode_d[M_GOSTEP] = mode[M_GOSTEP] | step_ok;
      mode_d[M_GO]     = mode[M_GO] | acc_ok;
    end else if (clr_we) begin
      mode_d = mode & ~wdata;
    end
    if (step_evt) mode_d[M_GOSTEP] = 1'b0;

    step_stop_d = clr_we & wdata[M_GOSTEP] & mode[M_GOSTEP];
    acc_stop_d  = clr_we & ~wdata[M_GOSTEP] & wdata[M_GO] & mode[M_GO];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode       <= '0;
      step_start <= 1'b0;
      step_stop  <= 1'b0;
      acc_start  <= 1'b0;
      acc_stop   <= 1'b0;
    end else begin
      mode       <= mode_d;
      step_start <= step_ok;
      step_stop  <= step_stop_d;
      acc_start  <= acc_ok;
      acc_stop   <= acc_stop_d;
    end
  end

  // R6
  go_bits_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(mode[M_GO] && mode[M_GOSTEP]));

  // R4
  step_start_new_chk: assert property (@(posedge clk) disable iff (!rst_n)
    step_start |-> (mode[M_GOSTEP] && !$past(mode[M_GOSTEP])));

  // R5
  acc_start_new_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc_start |-> (mode[M_GO] && !$past(mode[M_GO])));

  // R4
  step_pulse_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    step_start |=> !step_start);

  // R7
  step_stop_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    step_stop |-> !mode[M_GOSTEP]);

  // R6
  start_mutex_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({step_start, acc_start}) <= 1);
endmodule

// File: rtl/fdc_regif.sv
module fdc_regif
  import fdc_pkg::*;
#(
  parameter int         DW       = 8,
  parameter int         AW       = 4,
  parameter logic [2:0] STEP_CMD = 3'b000
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic          rd_en,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  output logic [DW-1:0] phase_o,
  output logic [DW-1:0] step_cnt_o,
  output logic [DW-1:0] first_sec_o,
  output logic [DW-1:0] xfer_cnt_o,
  output logic [DW-1:0] gap_o,
  output logic          wr_mode_o,
  output logic          step_start_o,
  output logic          step_stop_o,
  output logic          acc_start_o,
  output logic          acc_stop_o,
  input  logic          step_done_i,
  input  logic          hdr_valid_i,
  input  logic [DW-1:0] hdr_track_i,
  input  logic [DW-1:0] hdr_sector_i,
  input  logic [DW-1:0] hdr_format_i,
  input  logic [DW-1:0] eng_err_i,
  output logic          irq_o
);
  logic [DW-1:0] mode, err_q, flag_q, mask_q, track_q, sector_q, format_q;
  logic [DW-1:0] mode_err, flag_set, err_set_all;
  logic          step_evt, hdr_evt;
  logic          we_set, we_clr, rd_err, rd_flag;

  always_comb begin
    we_set   = wr_en && addr == AW'(A_MODE_SET);
    we_clr   = wr_en && addr == AW'(A_MODE_CLR);
    rd_err   = rd_en && addr == AW'(A_ERR);
    rd_flag  = rd_en && addr == AW'(A_IFLAG);
    hdr_evt  = hdr_valid_i & mode[M_GO];
    flag_set = '0;
    flag_set[F_STEP] = step_evt;
    flag_set[F_HDR]  = hdr_evt;
    err_set_all = mode_err | eng_err_i;
  end

  fdc_mode_ctl #(.DW(DW), .STEP_CMD(STEP_CMD)) u_mode (
    .clk        (clk),
    .rst_n      (rst_n),
    .set_we     (we_set),
    .clr_we     (we_clr),
    .wdata      (wdata),
    .phase      (phase_o[1:0]),
    .step_done  (step_done_i),
    .mode       (mode),
    .step_evt   (step_evt),
    .err_set    (mode_err),
    .step_start (step_start_o),
    .step_stop  (step_stop_o),
    .acc_start  (acc_start_o),
    .acc_stop   (acc_stop_o)
  );

  fdc_evt_reg #(.DW(DW)) u_flags (
    .clk      (clk),
    .rst_n    (rst_n),
    .rd_clr   (rd_flag),
    .set_bits (flag_set),
    .q        (flag_q)
  );

  fdc_evt_reg #(.DW(DW)) u_errs (
    .clk      (clk),
    .rst_n    (rst_n),
    .rd_clr   (rd_err),
    .set_bits (err_set_all),
    .q        (err_q)
  );

  // plain configuration registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_o     <= '0;
      step_cnt_o  <= '0;
      mask_q      <= '0;
      first_sec_o <= '1;
      xfer_cnt_o  <= '0;
      gap_o       <= '0;
    end else if (wr_en) begin
      case (addr)
        AW'(A_PHASE):  phase_o     <= wdata;
        AW'(A_STEP):   step_cnt_o  <= wdata;
        AW'(A_IMASK):  mask_q      <= wdata;
        AW'(A_FIRST):  first_sec_o <= wdata;
        AW'(A_XFER):   xfer_cnt_o  <= wdata;
        AW'(A_GAPFMT): gap_o       <= wdata;
        default: ;
      endcase
    end
  end

  // last address header seen by the access engine
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      track_q  <= '0;
      sector_q <= '0;
      format_q <= '0;
    end else if (hdr_evt) begin
      track_q  <= hdr_track_i;
      sector_q <= hdr_sector_i;
      format_q <= hdr_format_i;
    end
  end

  always_comb begin
    case (addr)
      AW'(A_ERR):      rdata = err_q;
      AW'(A_PHASE):    rdata = phase_o;
      AW'(A_STEP):     rdata = step_cnt_o;
      AW'(A_MODE_CLR): rdata = mode;
      AW'(A_MODE_SET): rdata = mode;
      AW'(A_IFLAG):    rdata = flag_q;
      AW'(A_IMASK):    rdata = mask_q;
      AW'(A_TRACK):    rdata = track_q;
      AW'(A_SECTOR):   rdata = sector_q;
      AW'(A_GAPFMT):   rdata = format_q;
      AW'(A_FIRST):    rdata = first_sec_o;
      AW'(A_XFER):     rdata = xfer_cnt_o;
      default:         rdata = '0;
    endcase
  end

  assign wr_mode_o = mode[M_WR];
  assign irq_o     = |(flag_q & mask_q);

  // R12
  irq_drops_on_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_flag && !step_evt && !hdr_evt) |=> !irq_o);

  // R9
  hdr_ignored_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hdr_valid_i && !mode[M_GO]) |=> ($stable(track_q) && $stable(format_q)));

  // R8
  step_done_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step_done_i && mode[M_GOSTEP]) |=> (!mode[M_GOSTEP] && flag_q[F_STEP]));
endmodule

// File: tb/sim_fdc_regif.sv
module sim_fdc_regif;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 0, rd_en = 0;
  logic [3:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata, phase_o, step_cnt_o, first_sec_o, xfer_cnt_o, gap_o;
  logic       wr_mode_o, step_start_o, step_stop_o, acc_start_o, acc_stop_o, irq_o;
  logic       step_done_i = 0, hdr_valid_i = 0;
  logic [7:0] hdr_track_i = '0, hdr_sector_i = '0, hdr_format_i = '0, eng_err_i = '0;

  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  fdc_regif u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .phase_o(phase_o), .step_cnt_o(step_cnt_o),
    .first_sec_o(first_sec_o), .xfer_cnt_o(xfer_cnt_o), .gap_o(gap_o),
    .wr_mode_o(wr_mode_o), .step_start_o(step_start_o), .step_stop_o(step_stop_o),
    .acc_start_o(acc_start_o), .acc_stop_o(acc_stop_o), .step_done_i(step_done_i),
    .hdr_valid_i(hdr_valid_i), .hdr_track_i(hdr_track_i), .hdr_sector_i(hdr_sector_i),
    .hdr_format_i(hdr_format_i), .eng_err_i(eng_err_i), .irq_o(irq_o)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; wr_en = 1;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [7:0] d);
    @(negedge clk); addr = a; rd_en = 1;
    #1 d = rdata;
    @(negedge clk); rd_en = 0;
  endtask

  task automatic rchk(input string req, input logic [3:0] a, input logic [7:0] exp);
    logic [7:0] v;
    rd(a, v);
    chk(req, v, exp);
  endtask

  task automatic hdr(input logic [7:0] t, input logic [7:0] s, input logic [7:0] f);
    @(negedge clk); hdr_valid_i = 1; hdr_track_i = t; hdr_sector_i = s; hdr_format_i = f;
    @(negedge clk); hdr_valid_i = 0;
  endtask

  task automatic sdone();
    @(negedge clk); step_done_i = 1;
    @(negedge clk); step_done_i = 0;
  endtask

  task automatic eerr(input logic [7:0] e);
    @(negedge clk); eng_err_i = e;
    @(negedge clk); eng_err_i = '0;
  endtask

  task automatic summary();
    finished = 1;
    $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    #(4 * 200000);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=running expected=done");
      summary();
    end
  end

  initial begin
    logic [7:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1;

    // R1 reset state
    for (int a = 0; a < 12; a++) rchk("R1 reset", 4'(a), (a == 10) ? 8'hFF : 8'h00);
    chk("R1 irq", irq_o, 0);
    chk("R1 pulses", {step_start_o, step_stop_o, acc_start_o, acc_stop_o}, 0);

    // R13 configuration registers, R2 unused addresses
    for (int k = 0; k < 16; k++) begin
      logic [7:0] d;
      d = 8'(k * 17 + 3);
      wr(1, d);  rchk("R13 phase", 1, d);  chk("R13 phase_o", phase_o, d);
      wr(2, d);  rchk("R13 step", 2, d);   chk("R13 step_cnt_o", step_cnt_o, d);
      wr(6, d);  rchk("R13 mask", 6, d);
      wr(10, d); rchk("R13 first", 10, d); chk("R13 first_sec_o", first_sec_o, d);
      wr(11, d); rchk("R13 xfer", 11, d);  chk("R13 xfer_cnt_o", xfer_cnt_o, d);
      wr(9, d);  chk("R13 gap_o", gap_o, d); rchk("R13 format unchanged", 9, 8'h00);
    end
    for (int a = 12; a < 16; a++) rchk("R2 unused", 4'(a), 8'h00);
    wr(1, 0); wr(6, 0);

    // R3 set/clear sweep on non-engine bits
    for (int d = 0; d < 256; d++) begin
      logic [7:0] m;
      m = 8'(d) & 8'h77;
      wr(4, m);
      chk("R3 no pulse", {step_start_o, acc_start_o}, 0);
      rchk("R3 set", 4, m);
      chk("R3 wr_mode_o", wr_mode_o, m[4]);
      wr(3, 8'(d));
      rchk("R3 clear", 3, m & ~8'(d));
      wr(3, 8'hFF);
    end
    rchk("R6 no error from plain bits", 0, 8'h00);

    // R4 / R6 step command address sweep
    for (int hi = 0; hi < 2; hi++) begin
      for (int ph = 0; ph < 4; ph++) begin
        bit ok;
        ok = ({hi[0], ph[1:0]} == 3'b000);
        wr(1, 8'(ph));
        wr(4, 8'h80 | 8'(hi << 5));
        chk("R4 step_start", step_start_o, ok);
        rchk("R4 mode", 4, (ok ? 8'h80 : 8'h00) | 8'(hi << 5));
        rchk("R6 cmd error", 0, ok ? 8'h00 : 8'h02);
        wr(3, 8'h80);
        chk("R7 step_stop", step_stop_o, ok);
        wr(3, 8'hFF);
      end
    end
    wr(1, 0);

    // R4 both go bits in one set: step wins
    wr(4, 8'h88);
    chk("R4 both bits step_start", step_start_o, 1);
    chk("R4 both bits acc_start", acc_start_o, 0);
    @(negedge clk); chk("R4 pulse one cycle", step_start_o, 0);
    rchk("R4 mode 0x80", 4, 8'h80);
    // R6 busy refusals while stepping
    wr(4, 8'h80); chk("R6 second step", step_start_o, 0); rchk("R6 busy err", 0, 8'h01);
    wr(4, 8'h08); chk("R6 access while step", acc_start_o, 0);
    rchk("R6 go untouched", 4, 8'h80); rchk("R6 busy err", 0, 8'h01);
    // R8 step done
    sdone();
    rchk("R8 step bit cleared", 4, 8'h00);
    rchk("R8 flag step", 5, 8'h02);
    rchk("R10 flags cleared", 5, 8'h00);
    sdone();
    rchk("R8 ignored when idle", 5, 8'h00);

    // R5 access
    wr(4, 8'h08);
    chk("R5 acc_start", acc_start_o, 1);
    rchk("R5 mode", 4, 8'h08);
    wr(4, 8'h80); chk("R6 step while access", step_start_o, 0); rchk("R6 busy err", 0, 8'h01);
    hdr(8'h85, 8'h8C, 8'h22);
    rchk("R9 track", 7, 8'h85); rchk("R9 sector", 8, 8'h8C); rchk("R9 format", 9, 8'h22);
    // R10 read collides with header event
    @(negedge clk); addr = 5; rd_en = 1; hdr_valid_i = 1;
    hdr_track_i = 8'h11; hdr_sector_i = 8'h12; hdr_format_i = 8'h13;
    #1 v = rdata;
    @(negedge clk); rd_en = 0; hdr_valid_i = 0;
    chk("R10 collide read old", v, 8'h04);
    rchk("R10 new flag survived", 5, 8'h04);
    rchk("R9 second track", 7, 8'h11);
    wr(3, 8'h08);
    chk("R7 acc_stop", acc_stop_o, 1);
    rchk("R7 mode idle", 4, 8'h00);
    hdr(8'h77, 8'h66, 8'h55);
    rchk("R9 ignored track", 7, 8'h11); rchk("R9 ignored format", 9, 8'h13);
    rchk("R9 ignored flags", 5, 8'h00);

    // R6 write-mode refusal
    wr(4, 8'h18);
    chk("R6 write refused", acc_start_o, 0);
    rchk("R6 write mode kept", 4, 8'h10);
    chk("R3 wr_mode_o", wr_mode_o, 1);
    rchk("R6 write err", 0, 8'h04);
    wr(3, 8'hFF);

    // R11 error accumulation and collision
    eerr(8'h40); eerr(8'h20);
    rchk("R11 errors ored", 0, 8'h60);
    eerr(8'h01);
    @(negedge clk); addr = 0; rd_en = 1; eng_err_i = 8'h80;
    #1 v = rdata;
    @(negedge clk); rd_en = 0; eng_err_i = 0;
    chk("R11 collide read old", v, 8'h01);
    rchk("R11 new error survived", 0, 8'h80);
    rchk("R11 cleared", 0, 8'h00);

    // R12 irq sweep over mask with flags 0x06
    wr(4, 8'h80); sdone();
    wr(4, 8'h08); hdr(1, 2, 3); wr(3, 8'h08);
    for (int m = 0; m < 256; m++) begin
      wr(6, 8'(m));
      chk("R12 irq", irq_o, (m & 6) != 0);
    end
    rchk("R12 flags", 5, 8'h06);
    chk("R12 irq after read", irq_o, 0);

    summary();
  end
endmodule